// File: doc/BRIEF.md
# Multi-Bank Synchronous Clock Divider

This block turns one fast internal clock into fourteen slower, phase-aligned clock-like signals. There are three banks of four lanes each, a feedback lane and a synchronization pulse. Each bank has its own set of even divide ratios. A first stage can halve the input rate, and every lane counts that common tick stream.

All counters start together when the active-low master reset/output enable is released. Rising edges of different lanes therefore line up whenever their periods share a multiple. The synchronization pulse is built to rise only on an edge where banks A and C both rise, whatever ratios are selected.

Each bank lane can be switched on or off at any time without a shortened pulse. A switched-off lane rests low. Its enable bit is taken into account only while the lane's own level is low. The upper two lanes of bank C can be driven inverted.

Top module: `clk_bank_divider`

## Requirements
- R1: When `pre_bypass` is low, the internal tick runs at half the input clock rate, with a tick on the first edge after release and every second edge after that. When `pre_bypass` is high, every edge is a tick. All ratios below are counted in ticks.
- R2: Bank A (`q_a`) divides by 4, 6, 8 or 12 for `sel_a` = 0, 1, 2 or 3. The output is high for the first half of each period.
- R3: Bank B (`q_b`) divides by 4, 6, 8 or 10 for `sel_b` = 0, 1, 2 or 3, with 50% duty.
- R4: Bank C (`q_c`) divides by 2, 4, 6 or 8 for `sel_c` = 0, 1, 2 or 3, with 50% duty.
- R5: `fb_clk` divides by 4, 6, 8 or 10 for `sel_fb[1:0]` = 0, 1, 2 or 3, with 50% duty. `sel_fb[2]` = 1 doubles the ratio.
- R6: With `inv_c_hi` high, `q_c[2]` and `q_c[3]` are the complement of the bank C level. With it low, they equal the level.
- R7: `sync_pulse` rises only in cycles where banks A and C both rise. It repeats every least-common-multiple of their ratios. It stays high for the smaller of the two ratios, or for half the ratio when both are equal.
- R8: While `mr_oe_n` is low, every output is low and every counter is cleared. After release, the tick numbered k (counting from 0 at the first edge) shows at the outputs one edge later. Every enabled, non-inverted lane therefore rises at the second edge after release.
- R9: `out_en` bit i gates bank lane i: bits 3:0 map to A0..A3, bits 7:4 to B0..B3, and bits 11:8 to C0..C3. A lane whose gate is off stays low. The gate takes `out_en[i]` only at edges where that lane's ungated level was low in the previous cycle, so no high phase is ever cut short or started late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| mr_oe_n | input | 1 | Active-low master reset and output enable (asynchronous assert) |
| pre_bypass | input | 1 | 1: tick every cycle; 0: tick every second cycle |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select, bit 2 doubles |
| inv_c_hi | input | 1 | Invert bank C lanes 2 and 3 |
| out_en | input | 12 | Per-lane enable for the bank lanes |
| q_a | output | 4 | Bank A lanes |
| q_b | output | 4 | Bank B lanes |
| q_c | output | 4 | Bank C lanes |
| fb_clk | output | 1 | Feedback divided clock |
| sync_pulse | output | 1 | Synchronization pulse aligned to A and C |

## Verification
The bench targets the selection of equal A and C ratios. A design that sizes the pulse as the full faster period would hold `sync_pulse` high forever. It also covers unrelated pairs such as 12 and 8, where a wrong repeat interval moves the pulse off the common edge.

Enables are flipped in high and low phases alike. A gate that loads at once would truncate a pulse or start a lane mid-phase.

Runs with the prescaler on and off, with the doubled feedback ratio, and with inversion on expose an off-by-one tick phase, a missing doubling, or inversion on the wrong lanes. Reset is asserted repeatedly mid-run to show that all lanes restart from a common first rising edge.

// File: rtl/clk_bank_div_pkg.sv
package clk_bank_div_pkg;

    // Counter width in ticks; the largest period used is the A/C lcm of 24.
    localparam int CNT_W    = 5;
    // Bank C ratios never exceed this, so lcm = ratio_a * m with m <= this.
    localparam int MAX_MULT = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t ratio_a(input logic [1:0] s);
        case (s)
            2'd0:    return cnt_t'(4);
            2'd1:    return cnt_t'(6);
            2'd2:    return cnt_t'(8);
            default: return cnt_t'(12);
        endcase
    endfunction

    function automatic cnt_t ratio_b(input logic [1:0] s);
        return cnt_t'(4 + 2 * int'(s));
    endfunction

    function automatic cnt_t ratio_c(input logic [1:0] s);
        return cnt_t'(2 + 2 * int'(s));
    endfunction

    function automatic cnt_t ratio_fb(input logic [2:0] s);
        int base;
        base = 4 + 2 * int'(s[1:0]);
        return s[2] ? cnt_t'(base * 2) : cnt_t'(base);
    endfunction

    // Smallest multiple of x that y divides.
    function automatic cnt_t lcm_of(input cnt_t x, input cnt_t y);
        cnt_t res;
        logic found;
        res   = x;
        found = 1'b0;
        for (int m = 1; m <= MAX_MULT; m++) begin
            if (!found && ((int'(x) * m) % int'(y)) == 0) begin
                res   = cnt_t'(int'(x) * m);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    // Pulse width: the faster period, or half of it when both match.
    function automatic cnt_t sync_high(input cnt_t x, input cnt_t y);
        if (x == y) return x >> 1;
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/clk_bank_div_tick.sv
module clk_bank_div_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    output logic tick,
    output logic run
);
    typedef struct packed {
        logic ph;
        logic run;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ph  = ~s_q.ph;
        s_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Phase 0 carries the tick, so the first edge after release ticks.
    assign tick = bypass | ~s_q.ph;
    assign run  = s_q.run;
endmodule

// File: rtl/clk_bank_div_counter.sv
module clk_bank_div_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] high_len,
    output logic          lvl
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.lvl = (s_q.cnt < high_len);
            s_d.cnt = (s_q.cnt >= period - ONE) ? '0 : s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.lvl;
endmodule

// File: rtl/clk_bank_div_outcell.sv
module clk_bank_div_outcell (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic lvl,
    input  logic inv,
    input  logic en,
    output logic q,
    output logic raw
);
    typedef struct packed {
        logic raw;
        logic gate;
        logic q;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.raw  = run & (lvl ^ inv);
        // The gate may only move while the lane rests low.
        s_d.gate = s_q.raw ? s_q.gate : en;
        s_d.q    = s_d.raw & s_d.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q   = s_q.q;
    assign raw = s_q.raw;
endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               mr_oe_n,
    input  logic               pre_bypass,
    input  logic [1:0]         sel_a,
    input  logic [1:0]         sel_b,
    input  logic [1:0]         sel_c,
    input  logic [2:0]         sel_fb,
    input  logic               inv_c_hi,
    input  logic [3*LANES-1:0] out_en,
    output logic [LANES-1:0]   q_a,
    output logic [LANES-1:0]   q_b,
    output logic [LANES-1:0]   q_c,
    output logic               fb_clk,
    output logic               sync_pulse
);
    import clk_bank_div_pkg::*;

    localparam int NOUT  = 3 * LANES;
    localparam int NCELL = NOUT + 2;
    localparam int C_LO  = 2 * LANES;
    localparam int C_INV = C_LO + LANES / 2;

    logic tick, run;
    logic lvl_a, lvl_b, lvl_c, lvl_fb, lvl_sync;
    cnt_t r_a, r_b, r_c, r_fb, r_sync, h_sync;
    logic [NCELL-1:0] raw_q;
    logic [NCELL-1:0] q_all;

    assign r_a    = ratio_a(sel_a);
    assign r_b    = ratio_b(sel_b);
    assign r_c    = ratio_c(sel_c);
    assign r_fb   = ratio_fb(sel_fb);
    assign r_sync = lcm_of(r_a, r_c);
    assign h_sync = sync_high(r_a, r_c);

    clk_bank_div_tick u_tick (
        .clk(clk), .rst_n(mr_oe_n), .bypass(pre_bypass), .tick(tick), .run(run)
    );

    clk_bank_div_counter #(.CW(CNT_W)) u_div_a (
        .clk(clk), .rst_n(mr_oe_n), .tick(tick),
        .period(r_a), .high_len(r_a >> 1), .lvl(lvl_a)
    );
    clk_bank_div_counter #(.CW(CNT_W)) u_div_b (
        .clk(clk), .rst_n(mr_oe_n), .tick(tick),
        .period(r_b), .high_len(r_b >> 1), .lvl(lvl_b)
    );
    clk_bank_div_counter #(.CW(CNT_W)) u_div_c (
        .clk(clk), .rst_n(mr_oe_n), .tick(tick),
        .period(r_c), .high_len(r_c >> 1), .lvl(lvl_c)
    );
    clk_bank_div_counter #(.CW(CNT_W)) u_div_fb (
        .clk(clk), .rst_n(mr_oe_n), .tick(tick),
        .period(r_fb), .high_len(r_fb >> 1), .lvl(lvl_fb)
    );
    clk_bank_div_counter #(.CW(CNT_W)) u_div_sync (
        .clk(clk), .rst_n(mr_oe_n), .tick(tick),
        .period(r_sync), .high_len(h_sync), .lvl(lvl_sync)
    );

    // One output cell per lane: bank lanes, then feedback, then sync.
    for (genvar i = 0; i < NCELL; i++) begin : g_out
        logic lvl_i, inv_i, en_i;

        if (i < LANES) begin : g_src_a
            assign lvl_i = lvl_a;
        end else if (i < C_LO) begin : g_src_b
            assign lvl_i = lvl_b;
        end else if (i < NOUT) begin : g_src_c
            assign lvl_i = lvl_c;
        end else if (i == NOUT) begin : g_src_fb
            assign lvl_i = lvl_fb;
        end else begin : g_src_sync
            assign lvl_i = lvl_sync;
        end

        if (i >= C_INV && i < NOUT) begin : g_inv
            assign inv_i = inv_c_hi;
        end else begin : g_noinv
            assign inv_i = 1'b0;
        end

        if (i < NOUT) begin : g_gated
            assign en_i = out_en[i];
        end else begin : g_always
            assign en_i = 1'b1;
        end

        clk_bank_div_outcell u_cell (
            .clk(clk), .rst_n(mr_oe_n), .run(run), .lvl(lvl_i),
            .inv(inv_i), .en(en_i), .q(q_all[i]), .raw(raw_q[i])
        );
    end

    assign q_a        = q_all[LANES-1:0];
    assign q_b        = q_all[C_LO-1:LANES];
    assign q_c        = q_all[NOUT-1:C_LO];
    assign fb_clk     = q_all[NOUT];
    assign sync_pulse = q_all[NOUT+1];
endmodule

// File: rtl/clk_bank_divider_chk.sv
module clk_bank_divider_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 mr_oe_n,
    input logic                 pre_bypass,
    input logic                 tick,
    input logic                 lvl_a,
    input logic                 lvl_c,
    input logic                 lvl_sync,
    input logic [3*LANES+1:0]   raw_q,
    input logic [3*LANES+1:0]   q_all
);
    localparam int NCELL = 3 * LANES + 2;

    // R8: everything quiet while held in reset.
    always @(negedge clk) begin
        if (!mr_oe_n) begin
            a_r8_reset_quiet: assert (q_all == '0)
                else $error("R8 outputs active during reset");
        end
    end

    // R1: with the prescaler active a tick is never followed by a tick.
    a_r1_half_rate: assert property (@(posedge clk) disable iff (!mr_oe_n)
        (tick && !pre_bypass) |=> (!tick || pre_bypass));

    // R2: divider levels move only on ticks.
    a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (!mr_oe_n)
        !tick |=> ($stable(lvl_a) && $stable(lvl_c)));

    // R7: sync rises only together with banks A and C.
    a_r7_sync_on_ac_rise: assert property (@(posedge clk) disable iff (!mr_oe_n)
        $rose(lvl_sync) |-> ($rose(lvl_a) && $rose(lvl_c)));

    // R9: every output edge is an edge of the ungated level (no runt).
    for (genvar i = 0; i < NCELL; i++) begin : g_lane
        a_r9_rise_whole: assert property (@(posedge clk) disable iff (!mr_oe_n)
            $rose(q_all[i]) |-> $rose(raw_q[i]));
        a_r9_fall_whole: assert property (@(posedge clk) disable iff (!mr_oe_n)
            $fell(q_all[i]) |-> $fell(raw_q[i]));
    end
endmodule

bind clk_bank_divider clk_bank_divider_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/clk_bank_divider_tb.sv
module clk_bank_divider_tb;
    logic        clk = 1'b0;
    logic        mr_oe_n = 1'b0;
    logic        pre_bypass = 1'b1;
    logic [1:0]  sel_a = '0, sel_b = '0, sel_c = '0;
    logic [2:0]  sel_fb = '0;
    logic        inv_c_hi = 1'b0;
    logic [11:0] out_en = '1;
    logic [3:0]  q_a, q_b, q_c;
    logic        fb_clk, sync_pulse;

    always #10 clk = ~clk;

    clk_bank_divider u_dut (
        .clk(clk), .mr_oe_n(mr_oe_n), .pre_bypass(pre_bypass),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c_hi(inv_c_hi), .out_en(out_en),
        .q_a(q_a), .q_b(q_b), .q_c(q_c), .fb_clk(fb_clk), .sync_pulse(sync_pulse)
    );

    typedef struct packed {
        logic [3:0] a, b, c;
        logic       fb, sy;
    } exp_t;

    exp_t        exp_q[$];
    int          n_checks = 0;
    int          n_err = 0;
    int          edge_n = 0;
    logic [13:0] prev_raw = '0;
    logic [11:0] gate = '0;

    function automatic int rat_a(input logic [1:0] s);
        case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
    endfunction
    function automatic int rat_b(input logic [1:0] s);
        case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 10; endcase
    endfunction
    function automatic int rat_c(input logic [1:0] s);
        case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
    endfunction
    function automatic int rat_fb(input logic [2:0] s);
        int b;
        case (s[1:0]) 2'd0: b = 4; 2'd1: b = 6; 2'd2: b = 8; default: b = 10; endcase
        return s[2] ? 2 * b : b;
    endfunction
    function automatic int lcm(input int x, input int y);
        for (int m = x; m <= x * y; m += x) if (m % y == 0) return m;
        return x * y;
    endfunction
    function automatic logic half_hi(input int k, input int r);
        return (k % r) < (r / 2);
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Driver/model: after each edge, push the outputs the requirements predict.
    always @(posedge clk) begin
        if (!mr_oe_n) begin
            edge_n   = 0;
            prev_raw = '0;
            gate     = '0;
        end else begin
            logic [13:0] raw;
            exp_t        e;
            raw = '0;
            if (edge_n > 0) begin
                int k, ra, rc, hs;
                k  = pre_bypass ? edge_n - 1 : (edge_n - 1) / 2;   // R1
                ra = rat_a(sel_a);
                rc = rat_c(sel_c);
                hs = (ra == rc) ? ra / 2 : (ra < rc ? ra : rc);
                for (int i = 0; i < 4; i++) begin
                    raw[i]     = half_hi(k, ra);
                    raw[4 + i] = half_hi(k, rat_b(sel_b));
                    raw[8 + i] = half_hi(k, rc) ^ (inv_c_hi && i >= 2);
                end
                raw[12] = half_hi(k, rat_fb(sel_fb));
                raw[13] = (k % lcm(ra, rc)) < hs;
            end
            for (int i = 0; i < 12; i++) if (!prev_raw[i]) gate[i] = out_en[i];
            e.a  = raw[3:0] & gate[3:0];
            e.b  = raw[7:4] & gate[7:4];
            e.c  = raw[11:8] & gate[11:8];
            e.fb = raw[12];
            e.sy = raw[13];
            exp_q.push_back(e);
            prev_raw = raw;
            edge_n++;
        end
    end

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string p;
            e = exp_q.pop_front();
            p = pre_bypass ? "" : "R1 ";
            chk({p, "R2/R9 bank A"}, int'(q_a), int'(e.a));
            chk({p, "R3/R9 bank B"}, int'(q_b), int'(e.b));
            chk({p, "R4/R9 bank C low lanes"}, int'(q_c[1:0]), int'(e.c[1:0]));
            chk({p, "R6/R9 bank C inverted lanes"}, int'(q_c[3:2]), int'(e.c[3:2]));
            chk({p, "R5 feedback"}, int'(fb_clk), int'(e.fb));
            chk({p, "R7 sync"}, int'(sync_pulse), int'(e.sy));
        end
    end

    task automatic run_case(input logic byp, input logic [1:0] a, input logic [1:0] b,
                            input logic [1:0] c, input logic [2:0] f, input logic inv,
                            input logic [11:0] en, input int cyc,
                            input logic [11:0] mask, input int every);
        @(negedge clk); #2;
        mr_oe_n    = 1'b0;
        pre_bypass = byp;
        sel_a = a; sel_b = b; sel_c = c; sel_fb = f;
        inv_c_hi   = inv;
        out_en     = en;
        for (int j = 0; j < 2; j++) begin
            @(negedge clk); #2;
            chk("R8 reset hold", int'({fb_clk, sync_pulse, q_c, q_b, q_a}), 0);
        end
        mr_oe_n = 1'b1;
        for (int j = 0; j < cyc; j++) begin
            @(negedge clk); #2;
            if (every > 0 && (j % every) == every - 1) out_en = out_en ^ mask;
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        run_case(1'b1, 2'd0, 2'd0, 2'd0, 3'b000, 1'b0, 12'hFFF,  80, 12'h000,  0);
        run_case(1'b0, 2'd3, 2'd3, 2'd1, 3'b111, 1'b1, 12'hFFF, 200, 12'h5A3, 37);
        run_case(1'b1, 2'd1, 2'd2, 2'd2, 3'b010, 1'b0, 12'hF0F, 150, 12'h0FF, 23);
        run_case(1'b1, 2'd2, 2'd1, 2'd3, 3'b101, 1'b1, 12'hFFF, 150, 12'hC30, 11);
        run_case(1'b0, 2'd3, 2'd0, 2'd3, 3'b011, 1'b0, 12'hFFF, 200, 12'hFFF, 29);
        run_case(1'b1, 2'd3, 2'd1, 2'd3, 3'b100, 1'b1, 12'h3C5, 120, 12'h9A6, 7);
        @(negedge clk); #2;
        mr_oe_n = 1'b0;
        @(negedge clk); #2;
        finish_run();
    end
endmodule